// File: doc/BRIEF.md
# Debug Test Access Port with Command Bridge Register

This block is a four-pin boundary-scan style test access port. It is used to reach an internal debug and programming engine from an external probe. The standard sixteen-state controller advances on each rising TCK edge under TMS. A 4-bit instruction register picks which data register sits between TDI and TDO. Three data registers are provided: a 32-bit identification word, a 1-bit bypass stage, and a 9-bit command bridge register.

When the bridge instruction is active, the debug engine's result is captured in parallel into the bridge register. The register is then scanned out, and in the same scan the next command is scanned in. On Update-DR the new word is presented in parallel to the engine, together with a single-cycle strobe. The whole port works only while a fuse input reads programmed and a software disable input is clear. The fuse input is expected to default to programmed, so the port is usable from reset. While the port is disabled it holds in Test-Logic-Reset and leaves TDO undriven.

Top module: `dbg_tap`

## Requirements
- R1: The port is enabled only while `fuse_ok` is 1 and `sw_dis` is 0. Otherwise the controller is forced to Test-Logic-Reset on every TCK rise, `tdo_oe` stays 0, and no update strobe occurs.
- R2: The controller follows the standard sixteen-state graph on rising TCK. Five consecutive TMS highs reach Test-Logic-Reset from any state. The Exit1/Pause/Exit2 path resumes shifting without losing bits.
- R3: TDO changes only on falling TCK. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R4: In Capture-IR the instruction shift stage loads 4'b0001. It shifts LSB first, and the new instruction takes effect in Update-IR.
- R5: Test-Logic-Reset selects the identification instruction, encoded 4'h3. Under it the 32-bit value `ID_WORD` is captured and scanned out LSB first.
- R6: Encoding 4'h7 selects the 9-bit bridge register. In Capture-DR it samples `cap_data`.
- R7: The bridge register shifts one bit per TCK, LSB first, with TDI entering at bit 8. A full 9-bit scan outputs the captured result while it loads the next command. Bit 8 is the flag bit and is the last bit scanned in.
- R8: In Update-DR under the bridge instruction, `upd_data` takes the shifted word and `upd_strobe` is 1 for exactly one TCK cycle. At no other time does `upd_data` change, and it is 0 after reset.
- R9: Every encoding other than 4'h3 and 4'h7 selects a 1-bit bypass stage that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled on TCK |
| fuse_ok | input | 1 | Fuse enable, 1 = programmed |
| sw_dis | input | 1 | Software disable, 1 = port off |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| cap_data | input | COMM_W | Result word from the debug engine |
| upd_data | output | COMM_W | Command word toward the debug engine |
| upd_strobe | output | 1 | One-cycle pulse when `upd_data` is refreshed |

## Verification
The bench runs randomized capture and command words through full bridge scans. A design that shifted MSB first, or that placed TDI at the wrong end, would return a scrambled result or deliver a scrambled command. It also splits a scan across a Pause-DR detour. A controller that shifted in Exit or Pause states would drop or duplicate a bit. Further checks cover the following corner cases:
- Unused encodings must give the one-cycle bypass delay with a leading 0.
- Five TMS highs, and asserting `sw_dis` or clearing `fuse_ok`, must all fall back to the identification word. A design that ignored the enable would keep driving TDO or emit a strobe.
- The strobe must last exactly one cycle. A design that held it longer, or changed `upd_data` outside Update-DR, is reported.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_TLR = 4'h0,
        ST_RTI,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_IDCODE,
        SEL_COMM
    } dr_sel_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'h3;
    localparam logic [IR_W-1:0] OP_COMM    = 4'h7;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e ir_decode(logic [IR_W-1:0] op);
        dr_sel_e d;
        case (op)
            OP_IDCODE: d = SEL_IDCODE;
            OP_COMM:   d = SEL_COMM;
            default:   d = SEL_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       en,
    input  logic       tms,
    output tap_state_e st
);

    always_ff @(posedge tck) begin
        if (rst || !en) begin
            st <= ST_TLR;
        end else begin
            st <= tap_next(st, tms);
        end
    end

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      st,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic [IR_W-1:0] ir_sr
);

    always_ff @(posedge tck) begin
        if (rst) begin
            ir    <= OP_IDCODE;
            ir_sr <= IR_CAPTURE;
        end else begin
            case (st)
                ST_TLR:    ir    <= OP_IDCODE;
                ST_CAP_IR: ir_sr <= IR_CAPTURE;
                ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: ir    <= ir_sr;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int               COMM_W  = 9,
    parameter logic [ID_W-1:0]  ID_WORD = 32'h1A2B_C03F
) (
    input  logic              tck,
    input  logic              rst,
    input  tap_state_e        st,
    input  dr_sel_e           sel,
    input  logic              tdi,
    input  logic [COMM_W-1:0] cap_data,
    output logic              dr_lsb,
    output logic [COMM_W-1:0] upd_data,
    output logic              upd_strobe
);

    logic [COMM_W-1:0] comm_sr;
    logic [ID_W-1:0]   id_sr;
    logic              byp;

    always_ff @(posedge tck) begin
        if (rst) begin
            comm_sr    <= '0;
            id_sr      <= '0;
            byp        <= 1'b0;
            upd_data   <= '0;
            upd_strobe <= 1'b0;
        end else begin
            upd_strobe <= 1'b0;
            case (st)
                ST_CAP_DR: begin
                    case (sel)
                        SEL_COMM:   comm_sr <= cap_data;
                        SEL_IDCODE: id_sr   <= ID_WORD;
                        default:    byp     <= 1'b0;
                    endcase
                end
                ST_SH_DR: begin
                    case (sel)
                        SEL_COMM:   comm_sr <= {tdi, comm_sr[COMM_W-1:1]};
                        SEL_IDCODE: id_sr   <= {tdi, id_sr[ID_W-1:1]};
                        default:    byp     <= tdi;
                    endcase
                end
                ST_UPD_DR: begin
                    if (sel == SEL_COMM) begin
                        upd_data   <= comm_sr;
                        upd_strobe <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_COMM:   dr_lsb = comm_sr[0];
            SEL_IDCODE: dr_lsb = id_sr[0];
            default:    dr_lsb = byp;
        endcase
    end

endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter int              COMM_W  = 9,
    parameter logic [ID_W-1:0] ID_WORD = 32'h1A2B_C03F
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              fuse_ok,
    input  logic              sw_dis,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic [COMM_W-1:0] cap_data,
    output logic [COMM_W-1:0] upd_data,
    output logic              upd_strobe
);

    logic            en;
    tap_state_e      st;
    logic [IR_W-1:0] ir;
    logic [IR_W-1:0] ir_sr;
    dr_sel_e         sel;
    logic            dr_lsb;

    assign en  = fuse_ok && !sw_dis;
    assign sel = ir_decode(ir);

    dbg_tap_fsm u_fsm (
        .tck (tck),
        .rst (rst),
        .en  (en),
        .tms (tms),
        .st  (st)
    );

    dbg_tap_ir u_ir (
        .tck   (tck),
        .rst   (rst),
        .st    (st),
        .tdi   (tdi),
        .ir    (ir),
        .ir_sr (ir_sr)
    );

    dbg_tap_dr #(
        .COMM_W  (COMM_W),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck        (tck),
        .rst        (rst),
        .st         (st),
        .sel        (sel),
        .tdi        (tdi),
        .cap_data   (cap_data),
        .dr_lsb     (dr_lsb),
        .upd_data   (upd_data),
        .upd_strobe (upd_strobe)
    );

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= en && (st == ST_SH_DR || st == ST_SH_IR);
            if (st == ST_SH_IR) begin
                tdo <= ir_sr[0];
            end else if (st == ST_SH_DR) begin
                tdo <= dr_lsb;
            end
        end
    end

endmodule

// File: rtl/dbg_tap_chk.sv
module dbg_tap_chk
    import dbg_tap_pkg::*;
#(
    parameter int COMM_W = 9
) (
    input logic              tck,
    input logic              rst,
    input logic              fuse_ok,
    input logic              sw_dis,
    input logic              tms,
    input logic              tdo_oe,
    input logic              upd_strobe,
    input logic [COMM_W-1:0] upd_data,
    input tap_state_e        st,
    input logic [IR_W-1:0]   ir_sr
);

    // R1
    port_off_holds_reset_chk: assert property (@(posedge tck) disable iff (rst)
        (!fuse_ok || sw_dis) |=> (st == ST_TLR));

    // R2
    tlr_leaves_to_idle_chk: assert property (@(posedge tck) disable iff (rst)
        (fuse_ok && !sw_dis && st == ST_TLR && !tms) |=> (st == ST_RTI));

    // R3
    oe_only_in_shift_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR));

    // R4
    ir_capture_value_chk: assert property (@(posedge tck) disable iff (rst)
        (st == ST_CAP_IR) |=> (ir_sr == 4'b0001));

    // R8
    strobe_single_cycle_chk: assert property (@(posedge tck) disable iff (rst)
        upd_strobe |=> !upd_strobe);

    // R8
    upd_data_quiet_chk: assert property (@(posedge tck) disable iff (rst)
        !upd_strobe |-> $stable(upd_data));

endmodule

bind dbg_tap dbg_tap_chk #(.COMM_W(COMM_W)) u_chk (
    .tck        (tck),
    .rst        (rst),
    .fuse_ok    (fuse_ok),
    .sw_dis     (sw_dis),
    .tms        (tms),
    .tdo_oe     (tdo_oe),
    .upd_strobe (upd_strobe),
    .upd_data   (upd_data),
    .st         (st),
    .ir_sr      (ir_sr)
);

// File: tb/tb_dbg_tap.sv
module tb_dbg_tap;

    localparam int          PERIOD  = 20;
    localparam int          COMM_W  = 9;
    localparam logic [31:0] ID_WORD = 32'h1A2B_C03F;

    logic              tck = 1'b0;
    logic              rst = 1'b1;
    logic              fuse_ok = 1'b1;
    logic              sw_dis = 1'b0;
    logic              tms = 1'b1;
    logic              tdi = 1'b0;
    logic              tdo;
    logic              tdo_oe;
    logic [COMM_W-1:0] cap_data = '0;
    logic [COMM_W-1:0] upd_data;
    logic              upd_strobe;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic last_tdo = 1'b0;

    dbg_tap #(.COMM_W(COMM_W), .ID_WORD(ID_WORD)) dut (
        .tck        (tck),
        .rst        (rst),
        .fuse_ok    (fuse_ok),
        .sw_dis     (sw_dis),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .cap_data   (cap_data),
        .upd_data   (upd_data),
        .upd_strobe (upd_strobe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        #(PERIOD/2);
        tck = 1'b1;
        #(PERIOD/2);
        tck = 1'b0;
        #1;
        last_tdo = tdo;
    endtask

    task automatic goto_shift_dr();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic goto_shift_ir();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan(input int n, input logic [31:0] din, input bit leave,
                        output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = last_tdo;
            step(leave && (i == n - 1), din[i]);
        end
    endtask

    task automatic exit_update();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
        logic [31:0] o;
        goto_shift_ir();
        scan(4, {28'h0, op}, 1'b1, o);
        cap = o[3:0];
        exit_update();
    endtask

    function automatic logic [31:0] bypass_expect(input int n, input logic [31:0] din);
        return (din << 1) & ((32'h1 << n) - 1);
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] o;
        logic [3:0]  c;
        logic [8:0]  cmd;
        logic [8:0]  cap;
        logic [8:0]  prev;
        void'($urandom(32'd4711));

        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        rst = 1'b0;
        // R8 reset state
        check("R8 reset upd_data", 32'(upd_data), 32'h0);
        check("R8 reset strobe", 32'(upd_strobe), 32'h0);
        check("R3 reset oe", 32'(tdo_oe), 32'h0);

        // R5 identification word after reset
        step(1'b0, 1'b0);
        goto_shift_dr();
        check("R3 oe in shift", 32'(tdo_oe), 32'h1);
        scan(32, 32'h0, 1'b1, o);
        check("R5 idcode", o, ID_WORD);
        check("R3 oe after shift", 32'(tdo_oe), 32'h0);
        exit_update();
        check("R8 no strobe for idcode", 32'(upd_strobe), 32'h0);

        // R4 capture value, select bridge register
        load_ir(4'h7, c);
        check("R4 ir capture", 32'(c), 32'h1);

        // R6 R7 R8 random bridge scans
        prev = '0;
        for (int k = 0; k < 20; k++) begin
            cap = 9'($urandom);
            cmd = 9'($urandom);
            if (k == 0) begin cap = 9'h1FF; cmd = 9'h100; end
            if (k == 1) begin cap = 9'h000; cmd = 9'h0FF; end
            cap_data = cap;
            goto_shift_dr();
            scan(9, {23'h0, cmd}, 1'b1, o);
            check("R6 R7 result out", o, {23'h0, cap});
            step(1'b1, 1'b0);
            check("R8 data held before update", 32'(upd_data), {23'h0, prev});
            check("R8 strobe low before update", 32'(upd_strobe), 32'h0);
            step(1'b0, 1'b0);
            check("R8 strobe", 32'(upd_strobe), 32'h1);
            check("R7 R8 command delivered", 32'(upd_data), {23'h0, cmd});
            step(1'b0, 1'b0);
            check("R8 strobe one cycle", 32'(upd_strobe), 32'h0);
            check("R3 oe idle", 32'(tdo_oe), 32'h0);
            prev = cmd;
        end

        // R2 R7 pause detour inside a scan
        cap = 9'h15A;
        cmd = 9'h0C3;
        cap_data = cap;
        goto_shift_dr();
        scan(5, {27'h0, cmd[4:0]}, 1'b1, o);
        check("R7 first part out", o, {27'h0, cap[4:0]});
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R3 oe in pause", 32'(tdo_oe), 32'h0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        scan(4, {28'h0, cmd[8:5]}, 1'b1, o);
        check("R2 R7 second part out", o, {28'h0, cap[8:5]});
        exit_update();
        check("R2 R8 split command", 32'(upd_data), {23'h0, cmd});

        // R9 bypass for unused and explicit bypass encodings
        load_ir(4'h5, c);
        goto_shift_dr();
        scan(8, 32'hB5, 1'b1, o);
        check("R9 bypass 5", o, bypass_expect(8, 32'hB5));
        exit_update();
        check("R9 no strobe in bypass", 32'(upd_strobe), 32'h0);
        load_ir(4'hF, c);
        goto_shift_dr();
        scan(8, 32'h6E, 1'b1, o);
        check("R9 bypass F", o, bypass_expect(8, 32'h6E));
        exit_update();

        // R2 five TMS highs from Shift-IR reach reset
        load_ir(4'h7, c);
        goto_shift_ir();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        goto_shift_dr();
        scan(32, 32'h0, 1'b1, o);
        check("R2 R5 reset via tms", o, ID_WORD);
        exit_update();

        // R1 software disable
        load_ir(4'h7, c);
        prev = upd_data;
        sw_dis = 1'b1;
        step(1'b0, 1'b0);
        goto_shift_dr();
        check("R1 oe off when disabled", 32'(tdo_oe), 32'h0);
        scan(9, 32'h1AA, 1'b1, o);
        exit_update();
        check("R1 no strobe when disabled", 32'(upd_strobe), 32'h0);
        check("R1 data kept when disabled", 32'(upd_data), {23'h0, prev});
        sw_dis = 1'b0;
        step(1'b0, 1'b0);
        goto_shift_dr();
        scan(32, 32'h0, 1'b1, o);
        check("R1 back to idcode", o, ID_WORD);
        exit_update();

        // R1 fuse not programmed
        fuse_ok = 1'b0;
        step(1'b0, 1'b0);
        goto_shift_dr();
        check("R1 oe off without fuse", 32'(tdo_oe), 32'h0);
        fuse_ok = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        goto_shift_dr();
        check("R1 fuse restored oe", 32'(tdo_oe), 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule